// File: doc/BRIEF.md
# Programmable Clock Divider With Lock

This block divides a reference clock by a ratio that software sets through one 32-bit control and status word. Software writes the ratio into a field of parameter width. It then raises a load bit in the same write or a later one. The divider does not switch to the new ratio at once: it waits for the end of the current output period. It then runs one full period at the new ratio and raises a lock flag. Software polls that flag to learn that the change is complete.

The same word also holds three more controls. An enable bit forces the divided clock low. A gate bit stops a buffered copy of the reference clock. A reset-request bit starts a self-timed reset pulse for a downstream domain, and that pulse lasts a parameter number of reference cycles. A ratio of 0 or 1 passes the reference clock through undivided. A build-time remap mode can force small ratios to values the hardware accepts, and a build-time option moves the lock flag to a second bit position.

Top module: `cdv_clkdiv`

## Requirements
- R1: After reset the enable, gate, reset-request and load bits read 0, the ratio field reads INIT_DIV (default 0), the lock flag reads 1, the divided output is low, and the reset-domain output is low.
- R2: Field positions in the control word: enable at bit 0, reset request at bit 1, load request at bit 2, ratio at bits 4 upward (DIV_W bits), buffered-clock gate at bit 28. The ratio field reads back the last value written to it.
- R3: An applied ratio of 0 or 1 makes the divided output follow the reference clock: it is high while the reference is high and low while the reference is low.
- R4: A write with bit 2 set is accepted in its own cycle. Lock reads 0 in the cycle that follows, and bit 2 always reads back 0.
- R5: After a load, lock rises only at the end of an output period. It rises after more than the new effective ratio cycles and no later than old plus new effective ratio plus one cycles. The effective ratio is 1 for 0 or 1, and the ratio itself otherwise.
- R6: The applied ratio changes only at the end of an output period. Every complete high or low phase seen across a change has the length of either the old ratio or the new ratio, so no runt pulse appears.
- R7: Writing the ratio field without bit 2 leaves the output period unchanged.
- R8: For an effective ratio N of 2 or more, the output is high for floor(N/2) reference cycles and low for N minus floor(N/2) cycles.
- R9: While enable is 0 the divided output stays low, and loads and lock still work.
- R10: The buffered reference output follows the reference clock while bit 28 is 0 and is held low while bit 28 is 1.
- R11: A write with bit 1 set drives the reset-domain output high for exactly RST_CYCLES reference cycles. Bit 1 reads 1 during the pulse and 0 after it.
- R12: SKIP_MODE remaps the ratio written with a load. Mode 0 applies it unchanged. Mode 1 turns 1 into 0. Mode 2 turns 1 and 2 into 0, and 3 into 4.
- R13: The lock flag sits at bit 31 when LOCK_ALT is 0 and at bit 27 when LOCK_ALT is 1. The other of those two bits reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control and status readback |
| div_clk_o | output | 1 | Divided clock output |
| buf_clk_o | output | 1 | Gated buffered reference clock |
| dom_rst_o | output | 1 | Reset pulse for the downstream domain |

## Verification
The bench watches every phase length while a load moves the ratio from 6 to 9. A divider that switched in the middle of a period would show a high or low phase that matches neither ratio. Odd ratios such as 5, 7 and 9 are measured, because a divider that rounds its half-period the wrong way gives phases of equal length or inverts the uneven split. Remapped ratios 1, 2 and 3 are loaded: a design that skips the remap would divide by 2 or 3 rather than passing through or dividing by 4. A ratio write without a load is made, and a design that applies fields without a strobe would change the period there. Loads with the output disabled check that the lock sequence does not depend on the enable.

// File: rtl/cdv_pkg.sv
package cdv_pkg;

  localparam int unsigned CW_EN      = 0;
  localparam int unsigned CW_RSTREQ  = 1;
  localparam int unsigned CW_LOAD    = 2;
  localparam int unsigned CW_RATIO   = 4;
  localparam int unsigned CW_BUFGATE = 28;
  localparam int unsigned CW_LOCK_HI = 31;
  localparam int unsigned CW_LOCK_LO = 27;

  typedef enum logic [1:0] {
    LK_HELD,
    LK_WAIT_EDGE,
    LK_WAIT_PERIOD
  } lk_state_e;

  // Remap of a written ratio before it is applied.
  function automatic int unsigned remap_ratio(int unsigned raw, int unsigned mode);
    int unsigned r;
    r = raw;
    if (mode == 1 && raw == 1) r = 0;
    if (mode == 2) begin
      if (raw == 1 || raw == 2) r = 0;
      else if (raw == 3) r = 4;
    end
    return r;
  endfunction

  // Cycles in one output period: 0 and 1 both mean one.
  function automatic int unsigned eff_ratio(int unsigned n);
    return (n <= 1) ? 1 : n;
  endfunction

  // High phase length; the odd leftover cycle goes to the low phase.
  function automatic int unsigned high_len(int unsigned n);
    return n >> 1;
  endfunction

endpackage

// File: rtl/cdv_ctl_reg.sv
module cdv_ctl_reg
  import cdv_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned INIT_DIV = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic             en_o,
  output logic             gate_o,
  output logic [DIV_W-1:0] ratio_o,
  output logic             load_o,
  output logic             rst_req_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      gate_o  <= 1'b0;
      ratio_o <= DIV_W'(INIT_DIV);
    end else if (wr_en_i) begin
      en_o    <= wr_data_i[CW_EN];
      gate_o  <= wr_data_i[CW_BUFGATE];
      ratio_o <= wr_data_i[CW_RATIO +: DIV_W];
    end
  end

  // Strobes are accepted in the write cycle and never stored.
  assign load_o    = wr_en_i & wr_data_i[CW_LOAD];
  assign rst_req_o = wr_en_i & wr_data_i[CW_RSTREQ];

endmodule

// File: rtl/cdv_rst_timer.sv
module cdv_rst_timer #(
  parameter int unsigned RST_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 left_q <= '0;
    else if (start_i)            left_q <= CNT_W'(RST_CYCLES);
    else if (left_q != '0)       left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);

endmodule

// File: rtl/cdv_div_core.sv
module cdv_div_core
  import cdv_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned INIT_DIV = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             wave_o,
  output logic             bypass_o,
  output logic             lock_o,
  output logic             period_end_o,
  output logic [DIV_W-1:0] act_o
);

  logic [DIV_W-1:0] act_q, pend_q, cnt_q;
  logic             pend_v_q;
  lk_state_e        st_q;
  logic [DIV_W-1:0] cur_len, nxt_len, nxt_cnt;
  logic             switch_now;

  assign cur_len      = DIV_W'(eff_ratio(int'(act_q)));
  assign period_end_o = (cnt_q == cur_len - 1'b1);
  assign switch_now   = period_end_o & pend_v_q;
  assign nxt_len      = switch_now ? DIV_W'(eff_ratio(int'(pend_q))) : cur_len;
  assign nxt_cnt      = period_end_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= DIV_W'(INIT_DIV);
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
      wave_o   <= 1'b0;
      lock_o   <= 1'b1;
      st_q     <= LK_HELD;
    end else begin
      cnt_q  <= nxt_cnt;
      wave_o <= (int'(nxt_cnt) < int'(high_len(int'(nxt_len))));
      if (switch_now) begin
        act_q    <= pend_q;
        pend_v_q <= 1'b0;
        st_q     <= LK_WAIT_PERIOD;
      end else if (period_end_o && st_q == LK_WAIT_PERIOD) begin
        lock_o <= 1'b1;
        st_q   <= LK_HELD;
      end
      // A fresh load overrides anything decided above.
      if (load_i) begin
        pend_q   <= ratio_i;
        pend_v_q <= 1'b1;
        lock_o   <= 1'b0;
        st_q     <= LK_WAIT_EDGE;
      end
    end
  end

  assign bypass_o = (act_q <= DIV_W'(1));
  assign act_o    = act_q;

endmodule

// File: rtl/cdv_clkdiv.sv
module cdv_clkdiv
  import cdv_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned INIT_DIV   = 0,
  parameter int unsigned SKIP_MODE  = 0,
  parameter bit          LOCK_ALT   = 1'b0,
  parameter int unsigned RST_CYCLES = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        div_clk_o,
  output logic        buf_clk_o,
  output logic        dom_rst_o
);

  localparam int unsigned LOCK_POS = LOCK_ALT ? CW_LOCK_LO : CW_LOCK_HI;

  logic             en_w, gate_w, load_w, rst_req_w;
  logic [DIV_W-1:0] ratio_w, mapped_w, act_n_w;
  logic             wave_w, bypass_w, lock_w, period_end_w;

  cdv_ctl_reg #(.DIV_W(DIV_W), .INIT_DIV(INIT_DIV)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .en_o(en_w), .gate_o(gate_w), .ratio_o(ratio_w),
    .load_o(load_w), .rst_req_o(rst_req_w)
  );

  assign mapped_w = DIV_W'(remap_ratio(int'(wr_data_i[CW_RATIO +: DIV_W]), SKIP_MODE));

  cdv_div_core #(.DIV_W(DIV_W), .INIT_DIV(INIT_DIV)) u_core (
    .clk_i, .rst_ni, .load_i(load_w), .ratio_i(mapped_w),
    .wave_o(wave_w), .bypass_o(bypass_w), .lock_o(lock_w),
    .period_end_o(period_end_w), .act_o(act_n_w)
  );

  cdv_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i, .rst_ni, .start_i(rst_req_w), .busy_o(dom_rst_o)
  );

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[CW_EN]                = en_w;
    rd_data_o[CW_RSTREQ]            = dom_rst_o;
    rd_data_o[CW_RATIO +: DIV_W]    = ratio_w;
    rd_data_o[CW_BUFGATE]           = gate_w;
    rd_data_o[LOCK_POS]             = lock_w;
  end

  assign div_clk_o = en_w & (bypass_w ? clk_i : wave_w);
  assign buf_clk_o = clk_i & ~gate_w;

endmodule

// File: rtl/cdv_clkdiv_chk.sv
module cdv_clkdiv_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [31:0]      wr_data_i,
  input logic             lock_w,
  input logic             period_end_w,
  input logic [DIV_W-1:0] act_n_w,
  input logic             dom_rst_o
);

  p_lock_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[2]) |=> !lock_w);

  p_lock_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_w) |-> $past(period_end_w));

  p_switch_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_w |=> $stable(act_n_w));

  p_rst_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1]) |=> dom_rst_o);

endmodule

bind cdv_clkdiv cdv_clkdiv_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .lock_w(lock_w), .period_end_w(period_end_w), .act_n_w(act_n_w),
  .dom_rst_o(dom_rst_o)
);

// File: tb/sim_cdv_clkdiv.sv
`timescale 1ns/1ps
module sim_cdv_clkdiv;

  localparam int DW   = 8;
  localparam int MODE = 2;
  localparam int RSTC = 100;
  localparam int LKB  = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        div_clk, buf_clk, dom_rst;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  cdv_clkdiv #(.DIV_W(DW), .INIT_DIV(0), .SKIP_MODE(MODE), .LOCK_ALT(1'b1),
               .RST_CYCLES(RSTC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .div_clk_o(div_clk), .buf_clk_o(buf_clk),
    .dom_rst_o(dom_rst)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // Bench-side model of the ratio rules.
  function automatic int b_map(int raw);
    if (raw == 1 || raw == 2) return 0;
    if (raw == 3) return 4;
    return raw;
  endfunction
  function automatic int b_len(int m);
    return (m < 2) ? 1 : m;
  endfunction
  function automatic int b_hi(int n);
    return (n - (n % 2)) / 2;
  endfunction
  function automatic int b_lo(int n);
    return n - b_hi(n);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk); #2; wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cw(bit en, bit load, int ratio);
    return {19'd0, 8'(ratio), 4'd0} | 32'(en) | (load ? 32'h4 : 32'h0);
  endfunction

  task automatic wait_lock(output int n);
    n = 0;
    while (!rd_data[LKB] && n < 3000) begin tick(); n++; end
  endtask

  task automatic measure(output int hi, output int lo);
    int guard = 0;
    logic prev;
    hi = 0; lo = 0;
    prev = div_clk;
    while (!(prev == 1'b0 && div_clk == 1'b1) && guard < 600) begin
      prev = div_clk; tick(); guard++;
    end
    while (div_clk && hi < 600) begin hi++; tick(); end
    while (!div_clk && lo < 600) begin lo++; tick(); end
  endtask

  task automatic check_bypass(input string tag);
    tick();
    chk(div_clk == 1'b1, tag, div_clk, 1);
    @(negedge clk); #2;
    chk(div_clk == 1'b0, tag, div_clk, 0);
  endtask

  task automatic load_and_check(input int raw, input int old_len, input string tag);
    int n, hi, lo, nl;
    nl = b_len(b_map(raw));
    wr(cw(1, 1, raw));
    chk(rd_data[LKB] == 1'b0, {tag, " R4 lock low"}, rd_data[LKB], 0);
    wait_lock(n);
    chk(n > nl && n <= old_len + nl + 1, {tag, " R5 lock time"}, n, nl);
    if (nl >= 2) begin
      measure(hi, lo);
      chk(hi == b_hi(nl), {tag, " R8 high"}, hi, b_hi(nl));
      chk(lo == b_lo(nl), {tag, " R8 low"}, lo, b_lo(nl));
    end else begin
      check_bypass({tag, " R3 pass"});
    end
  endtask

  initial begin
    int n, hi, lo, cur, bad, len, first, tot, nw;
    logic prev;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tick();
    // R1 reset state, R13 lock at bit 27
    chk(rd_data == 32'h0800_0000, "R1 reset word", rd_data, 32'h0800_0000);
    chk(rd_data[31] == 1'b0, "R13 bit31 clear", rd_data[31], 0);
    chk(div_clk == 1'b0 && dom_rst == 1'b0, "R1 outputs", {div_clk, dom_rst}, 0);
    chk(buf_clk == 1'b1, "R10 buffer runs", buf_clk, 1);

    // enable with ratio 0: pass-through
    wr(cw(1, 0, 0));
    check_bypass("R3 ratio0");
    cur = 1;

    // load 6
    load_and_check(6, cur, "r6a");
    cur = 6;
    chk(rd_data[11:4] == 8'd6 && rd_data[2] == 1'b0, "R2 field readback",
        rd_data[11:0], 12'h061);

    // R7: ratio write without load
    wr(cw(1, 0, 9));
    chk(rd_data[11:4] == 8'd9, "R2 raw field", rd_data[11:4], 9);
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R7 period unchanged", hi + lo, 6);

    // R6: watch phases across the change 6 -> 9
    nw = 9; bad = 0; first = 1; len = 0;
    wr(cw(1, 1, nw));
    prev = div_clk; tot = cur + 3 * nw + 4;
    for (int i = 0; i < tot; i++) begin
      tick();
      if (div_clk == prev) len++;
      else begin
        if (!first) begin
          if (prev && !(len == b_hi(cur) || len == b_hi(nw))) bad++;
          if (!prev && !(len == b_lo(cur) || len == b_lo(nw))) bad++;
        end
        first = 0; prev = div_clk; len = 1;
      end
    end
    chk(bad == 0, "R6 no runt phase", bad, 0);
    wait_lock(n);
    measure(hi, lo);
    chk(hi == 4 && lo == 5, "R8 odd 9", hi * 16 + lo, 16'h45);
    cur = 9;

    // R12 remap: 3 -> 4, 2 -> 0, 1 -> 0
    load_and_check(3, cur, "R12 raw3"); cur = 4;
    load_and_check(2, cur, "R12 raw2"); cur = 1;
    load_and_check(1, cur, "R12 raw1"); cur = 1;
    load_and_check(5, cur, "r5"); cur = 5;

    // R9: disabled output stays low, lock still cycles
    wr(cw(0, 0, 5));
    bad = 0;
    for (int i = 0; i < 12; i++) begin tick(); if (div_clk) bad++; end
    chk(bad == 0, "R9 held low", bad, 0);
    wr(cw(0, 1, 7));
    chk(rd_data[LKB] == 1'b0, "R9 lock drops", rd_data[LKB], 0);
    bad = 0; n = 0;
    while (!rd_data[LKB] && n < 200) begin tick(); n++; if (div_clk) bad++; end
    chk(n > 7 && n <= cur + 8 && bad == 0, "R9 lock while off", n, 7);
    cur = 7;
    wr(cw(1, 0, 7));

    // R10 buffer gate
    wr(cw(1, 0, 7) | 32'h1000_0000);
    chk(buf_clk == 1'b0 && rd_data[28], "R10 gated", buf_clk, 0);
    wr(cw(1, 0, 7));
    chk(buf_clk == 1'b1, "R10 ungated", buf_clk, 1);

    // R11 reset pulse
    wr(cw(1, 0, 7) | 32'h2);
    chk(rd_data[1] == 1'b1, "R11 busy bit", rd_data[1], 1);
    n = 0;
    while (dom_rst && n < 1000) begin n++; tick(); end
    chk(n == RSTC, "R11 pulse length", n, RSTC);
    chk(rd_data[1] == 1'b0, "R11 bit clears", rd_data[1], 0);

    // random loads
    for (int k = 0; k < 10; k++) begin
      int raw;
      raw = int'($urandom(32'd77 + k) % 24);
      load_and_check(raw, cur, "rand R5");
      cur = b_len(b_map(raw));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule